// File: doc/BRIEF.md
# Banked Sliding-Window Integral Memory

This block holds a horizontal stripe of an integral image so that a feature-extraction pipeline can fetch the corner values of box filters without stalling. The stripe is a fixed number of image rows deep and moves down the image one row at a time. Each new integral row is written into the slot that the oldest row used, so the image row `y` always lives in slot `y mod ROWS`. The caller decides when the window advances and where the integral values come from. The block does not check whether a requested row is still resident.

Storage is split across `NBANK` single-write, single-read RAM banks. A coordinate (x, y) goes to bank `(x + SKEW*y) mod NBANK`, at word `(x div NBANK) + (y mod ROWS) * (COLS/NBANK)`. Because of this skew, the four corners of most box shapes fall in different banks. Up to `NREQ` coordinates can be requested in one cycle. The data comes back in request order two cycles later. If two valid requests select the same bank, a conflict flag is raised together with that data. The lower-numbered request wins the bank, and the data for the request that lost is not meaningful.

Row loads use the write port of every bank. A load is a burst of `COLS/NBANK` beats. Each beat carries `NBANK` consecutive columns, and the beat index selects the column block. The full stripe is obtained with `COLS=512` and `ROWS=130`. The defaults are smaller so that the default build stays compact.

Top module: `haar_window_mem`

## Requirements
- R1: Coordinate (x, y) is stored in bank `(x + 3*y) mod 16` at word `(x div 16) + (y mod ROWS)*(COLS/16)`. A read returns exactly the value most recently written for that column and row.
- R2: Image rows y and y+ROWS share one slot. Loading row y+ROWS replaces row y and leaves every other slot unchanged.
- R3: A write beat with block index b loads columns 16*b+j, for j = 0..15, from lane j of `wr_data` (bits 32*j+31 : 32*j) for row `wr_y`.
- R4: Up to 8 requests presented in one cycle return their data in the same cycle, two clock edges after capture. Lane i of `out_data` (bits 32*i+31 : 32*i) carries request i, and nothing is returned one edge after capture.
- R5: `out_valid` equals the `rd_valid` mask captured two edges earlier.
- R6: `out_conflict` is high, aligned with the data, when two or more valid requests in the same cycle select one bank. It is low otherwise.
- R7: On a conflict, the lowest-numbered valid request for the contested bank gets correct data, and so does every request that uses an uncontested bank.
- R8: Requests whose `rd_valid` bit is 0 take no part in conflict detection and do not disturb the data of valid requests.
- R9: The four corners of a box of width w and height h read without conflict whenever w, h, w+3h and w-3h are all non-zero mod 16.
- R10: While `rst_n` is low, `out_valid` is 0 and `out_conflict` is 0 after the next edge.
- R11: A row-load beat and a read of a different slot in the same cycle both complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Row-load beat strobe |
| wr_y | input | YW (9) | Image row being loaded |
| wr_blk | input | log2(COLS/NBANK) (3) | Column block of this beat |
| wr_data | input | NBANK*DW (512) | 16 values, lane j = column 16*blk+j |
| rd_valid | input | NREQ (8) | Request valid mask |
| rd_x | input | NREQ*XW (56) | Request columns, request i at bits i*XW |
| rd_y | input | NREQ*YW (72) | Request rows, request i at bits i*YW |
| out_valid | output | NREQ (8) | Returned valid mask |
| out_conflict | output | 1 | Bank conflict in the returned group |
| out_data | output | NREQ*DW (256) | Returned values in request order |

## Verification
Reads of rows that share no slot, groups of eight requests spread over all banks, and a box-corner group show whether the skewed bank index and the in-bank word are formed correctly. They also show whether the return crossbar keeps request order. Two requests aimed at one bank, first with both valid and then with the lower one masked off, separate true conflict detection from detection that ignores the mask, and show which request is given the bank. Loading a row one window depth further down, and streaming a load during reads of another slot, show whether slots are reused circularly and whether the two bank ports stay independent.

// File: rtl/hwm_pkg.sv
// Package: default geometry of the sliding integral window.
// Assumes NBANK is a power of two and COLS is a multiple of NBANK.
package hwm_pkg;
    localparam int DEF_COLS  = 128;  // columns held per row
    localparam int DEF_ROWS  = 20;   // rows resident in the window
    localparam int DEF_NBANK = 16;   // number of RAM banks
    localparam int DEF_NREQ  = 8;    // parallel read requests
    localparam int DEF_DW    = 32;   // integral value width
    localparam int DEF_YW    = 9;    // image row index width
    localparam int DEF_SKEW  = 3;    // row multiplier of the bank skew
endpackage

// File: rtl/hwm_addr_map.sv
// Module: maps one (x, y) coordinate to a bank and a word inside that bank.
// Assumes NBANK is a power of two; the row slot is y modulo ROWS.
module hwm_addr_map #(
    parameter int COLS  = 128,
    parameter int ROWS  = 20,
    parameter int NBANK = 16,
    parameter int YW    = 9,
    parameter int SKEW  = 3,
    localparam int XW   = $clog2(COLS),
    localparam int BW   = $clog2(NBANK),
    localparam int WPR  = COLS / NBANK,
    localparam int AW   = $clog2(WPR * ROWS)
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    output logic [BW-1:0] bank,
    output logic [AW-1:0] addr
);
    // Skewed bank index and circular row-slot word address.
    always_comb begin
        bank = BW'(32'(x) + 32'(SKEW) * 32'(y));
        addr = AW'((32'(x) >> BW) + (32'(y) % 32'(ROWS)) * 32'(WPR));
    end
endmodule

// File: rtl/hwm_bank_arb.sv
// Module: assigns each bank to the lowest-numbered valid request that
// selects it and flags any group where two valid requests share a bank.
// Assumes bank and address of each request are already computed.
module hwm_bank_arb #(
    parameter int NREQ  = 8,
    parameter int NBANK = 16,
    parameter int AW    = 8,
    localparam int BW   = $clog2(NBANK)
) (
    input  logic [NREQ-1:0]     req_valid,
    input  logic [NREQ*BW-1:0]  req_bank,
    input  logic [NREQ*AW-1:0]  req_addr,
    output logic [NBANK-1:0]    bank_en,
    output logic [NBANK*AW-1:0] bank_addr,
    output logic                conflict
);
    // Per-bank selection; scanning downward leaves the lowest index winning.
    always_comb begin
        bank_en   = '0;
        bank_addr = '0;
        for (int k = 0; k < NBANK; k++) begin
            for (int i = NREQ - 1; i >= 0; i--) begin
                if (req_valid[i] && req_bank[i*BW +: BW] == BW'(k)) begin
                    bank_en[k]            = 1'b1;
                    bank_addr[k*AW +: AW] = req_addr[i*AW +: AW];
                end
            end
        end
    end

    // Pairwise comparison of valid requests for a shared bank.
    always_comb begin
        conflict = 1'b0;
        for (int i = 0; i < NREQ; i++) begin
            for (int j = i + 1; j < NREQ; j++) begin
                if (req_valid[i] && req_valid[j] &&
                    req_bank[i*BW +: BW] == req_bank[j*BW +: BW])
                    conflict = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hwm_bank_ram.sv
// Module: one bank with a write port and a registered read port.
// Assumes a read and a write of the same word never coincide.
module hwm_bank_ram #(
    parameter int DEPTH = 160,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Write port, dedicated to row loads.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Read port, one cycle of latency.
    always_ff @(posedge clk) begin
        if (re)
            rdata <= mem[raddr];
    end
endmodule

// File: rtl/haar_window_mem.sv
// Module: banked sliding-window store for integral-image rows with a
// parallel read path returning NREQ values in request order after two edges.
// Assumes reads stay inside the resident window; that is not checked.
module haar_window_mem #(
    parameter int COLS  = hwm_pkg::DEF_COLS,
    parameter int ROWS  = hwm_pkg::DEF_ROWS,
    parameter int NBANK = hwm_pkg::DEF_NBANK,
    parameter int NREQ  = hwm_pkg::DEF_NREQ,
    parameter int DW    = hwm_pkg::DEF_DW,
    parameter int YW    = hwm_pkg::DEF_YW,
    parameter int SKEW  = hwm_pkg::DEF_SKEW,
    localparam int XW   = $clog2(COLS),
    localparam int BW   = $clog2(NBANK),
    localparam int WPR  = COLS / NBANK,
    localparam int BLKW = $clog2(WPR),
    localparam int DEPTH = WPR * ROWS,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [YW-1:0]       wr_y,
    input  logic [BLKW-1:0]     wr_blk,
    input  logic [NBANK*DW-1:0] wr_data,
    input  logic [NREQ-1:0]     rd_valid,
    input  logic [NREQ*XW-1:0]  rd_x,
    input  logic [NREQ*YW-1:0]  rd_y,
    output logic [NREQ-1:0]     out_valid,
    output logic                out_conflict,
    output logic [NREQ*DW-1:0]  out_data
);
    logic [NREQ*BW-1:0]  req_bank;
    logic [NREQ*AW-1:0]  req_addr;
    logic [NBANK-1:0]    arb_en;
    logic [NBANK*AW-1:0] arb_addr;
    logic                arb_conf;

    logic [NBANK-1:0]    s1_en;
    logic [NBANK*AW-1:0] s1_addr;
    logic [NREQ*BW-1:0]  s1_bank;
    logic [NREQ-1:0]     s1_valid;
    logic                s1_conf;
    logic [NREQ*BW-1:0]  s2_bank;
    logic [NREQ-1:0]     s2_valid;
    logic                s2_conf;

    logic [AW-1:0]       wr_addr;
    logic [NBANK*DW-1:0] bank_wdata;
    logic [NBANK*DW-1:0] bank_q;

    // Address mapping, one instance per request lane.
    for (genvar i = 0; i < NREQ; i++) begin : g_map
        hwm_addr_map #(
            .COLS(COLS), .ROWS(ROWS), .NBANK(NBANK), .YW(YW), .SKEW(SKEW)
        ) map_i (
            .x   (rd_x[i*XW +: XW]),
            .y   (rd_y[i*YW +: YW]),
            .bank(req_bank[i*BW +: BW]),
            .addr(req_addr[i*AW +: AW])
        );
    end

    hwm_bank_arb #(
        .NREQ(NREQ), .NBANK(NBANK), .AW(AW)
    ) arb_i (
        .req_valid(rd_valid),
        .req_bank (req_bank),
        .req_addr (req_addr),
        .bank_en  (arb_en),
        .bank_addr(arb_addr),
        .conflict (arb_conf)
    );

    // Stage 1: capture per-bank read commands and per-request routing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_en    <= '0;
            s1_valid <= '0;
            s1_conf  <= 1'b0;
            s1_addr  <= '0;
            s1_bank  <= '0;
        end else begin
            s1_en    <= arb_en;
            s1_valid <= rd_valid;
            s1_conf  <= arb_conf;
            s1_addr  <= arb_addr;
            s1_bank  <= req_bank;
        end
    end

    // Stage 2: routing travels alongside the bank read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= '0;
            s2_conf  <= 1'b0;
            s2_bank  <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_conf  <= s1_conf;
            s2_bank  <= s1_bank;
        end
    end

    // Row-load word: column block plus circular slot offset.
    always_comb begin
        wr_addr = AW'(32'(wr_blk) + (32'(wr_y) % 32'(ROWS)) * 32'(WPR));
    end

    // Row-load lane rotation: bank k takes the column whose skewed bank is k.
    always_comb begin
        for (int k = 0; k < NBANK; k++) begin
            bank_wdata[k*DW +: DW] =
                wr_data[32'(BW'(32'(k) - 32'(SKEW) * 32'(wr_y))) * DW +: DW];
        end
    end

    for (genvar k = 0; k < NBANK; k++) begin : g_bank
        hwm_bank_ram #(
            .DEPTH(DEPTH), .DW(DW)
        ) ram_i (
            .clk  (clk),
            .we   (wr_en),
            .waddr(wr_addr),
            .wdata(bank_wdata[k*DW +: DW]),
            .re   (s1_en[k]),
            .raddr(s1_addr[k*AW +: AW]),
            .rdata(bank_q[k*DW +: DW])
        );
    end

    // Return crossbar: each lane picks the bank its request selected.
    always_comb begin
        for (int i = 0; i < NREQ; i++) begin
            out_data[i*DW +: DW] = bank_q[32'(s2_bank[i*BW +: BW]) * DW +: DW];
        end
    end

    assign out_valid    = s2_valid;
    assign out_conflict = s2_conf;
endmodule

// File: rtl/hwm_checker.sv
// Checker: timing relations between the read request and return ports.
// Assumes it is bound to haar_window_mem.
module hwm_checker #(
    parameter int NREQ = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NREQ-1:0] rd_valid,
    input logic [NREQ-1:0] out_valid,
    input logic            out_conflict
);
    logic [1:0] since_rst;

    // Counts edges since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (out_valid == $past(rd_valid, 2))); // R5

    AST_CONFLICT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        out_conflict |-> ($countones(out_valid) >= 2)); // R6

    AST_LONE_NO_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(rd_valid) <= 1) |-> ##2 !out_conflict); // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (out_valid == '0 && !out_conflict)); // R10
endmodule

bind haar_window_mem hwm_checker #(.NREQ(NREQ)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_valid    (rd_valid),
    .out_valid   (out_valid),
    .out_conflict(out_conflict)
);

// File: tb/haar_window_mem_tb_top.sv
module haar_window_mem_tb_top;
    localparam int COLS  = 128;
    localparam int ROWS  = 20;
    localparam int NBANK = 16;
    localparam int NREQ  = 8;
    localparam int DW    = 32;
    localparam int YW    = 9;
    localparam int XW    = 7;
    localparam int WPR   = COLS / NBANK;
    localparam int BLKW  = 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                wr_en = 1'b0;
    logic [YW-1:0]       wr_y = '0;
    logic [BLKW-1:0]     wr_blk = '0;
    logic [NBANK*DW-1:0] wr_data = '0;
    logic [NREQ-1:0]     rd_valid = '0;
    logic [NREQ*XW-1:0]  rd_x = '0;
    logic [NREQ*YW-1:0]  rd_y = '0;
    logic [NREQ-1:0]     out_valid;
    logic                out_conflict;
    logic [NREQ*DW-1:0]  out_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int qx [NREQ];
    int qy [NREQ];
    logic [NREQ-1:0] qv;

    always #10 clk = ~clk;

    haar_window_mem dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_y(wr_y), .wr_blk(wr_blk),
        .wr_data(wr_data), .rd_valid(rd_valid), .rd_x(rd_x), .rd_y(rd_y),
        .out_valid(out_valid), .out_conflict(out_conflict), .out_data(out_data)
    );

    function automatic logic [DW-1:0] val(int x, int y);
        return {8'hA5, 12'(y), 12'(x)};
    endfunction

    task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_beat(int y, int b);
        wr_en  = 1'b1;
        wr_y   = YW'(y);
        wr_blk = BLKW'(b);
        for (int j = 0; j < NBANK; j++)
            wr_data[j*DW +: DW] = val(NBANK * b + j, y);
    endtask

    // R3: full row load, beat b carries columns 16b..16b+15.
    task automatic load_row(int y);
        for (int b = 0; b < WPR; b++) begin
            @(negedge clk);
            load_beat(y, b);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_req();
        qv = '0;
        for (int i = 0; i < NREQ; i++) begin
            qx[i] = 0;
            qy[i] = 0;
        end
    endtask

    // Issues the queued group at a negedge; the caller has already aligned it.
    task automatic drive_req();
        rd_valid = qv;
        for (int i = 0; i < NREQ; i++) begin
            rd_x[i*XW +: XW] = XW'(qx[i]);
            rd_y[i*YW +: YW] = YW'(qy[i]);
        end
    endtask

    // R4 timing: nothing after one edge, data after two.
    task automatic finish_read(string req, logic [NREQ-1:0] chk, bit exp_conf);
        @(posedge clk);
        @(negedge clk);
        rd_valid = '0;
        wr_en = 1'b0;
        check(out_valid == '0, "R4 no early return", DW'(out_valid), '0);
        @(posedge clk);
        @(negedge clk);
        check(out_valid == qv, "R5 valid mask", DW'(out_valid), DW'(qv));
        check(out_conflict == exp_conf, "R6 conflict flag", DW'(out_conflict), DW'(exp_conf));
        for (int i = 0; i < NREQ; i++) begin
            if (chk[i])
                check(out_data[i*DW +: DW] == val(qx[i], qy[i]), req,
                      out_data[i*DW +: DW], val(qx[i], qy[i]));
        end
    endtask

    task automatic do_read(string req, logic [NREQ-1:0] chk, bit exp_conf);
        @(negedge clk);
        drive_req();
        finish_read(req, chk, exp_conf);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(out_valid == '0, "R10 reset valid", DW'(out_valid), '0);
        check(out_conflict == 1'b0, "R10 reset conflict", DW'(out_conflict), '0);
    endtask

    task automatic t_single();
        clear_req();
        qv[0] = 1'b1; qx[0] = 0; qy[0] = 0;
        do_read("R1 single (0,0)", 8'h01, 1'b0);
        clear_req();
        qv[0] = 1'b1; qx[0] = 127; qy[0] = 19;
        do_read("R1 single (127,19)", 8'h01, 1'b0);
        clear_req();
        qv[0] = 1'b1; qx[0] = 37; qy[0] = 11;
        do_read("R3 single (37,11)", 8'h01, 1'b0);
    endtask

    task automatic t_parallel();
        clear_req();
        qv = '1;
        for (int i = 0; i < NREQ; i++) begin
            qx[i] = i; qy[i] = 3;
        end
        do_read("R4 row group", 8'hFF, 1'b0);
        clear_req();
        qv = '1;
        qx[0] = 127; qy[0] = 19;  qx[1] = 64; qy[1] = 0;
        qx[2] = 5;   qy[2] = 10;  qx[3] = 100; qy[3] = 7;
        qx[4] = 33;  qy[4] = 12;  qx[5] = 71; qy[5] = 1;
        qx[6] = 15;  qy[6] = 15;  qx[7] = 50; qy[7] = 4;
        do_read("R1 scattered group", 8'hFF, 1'b0);
    endtask

    task automatic t_haar();
        clear_req();
        qv = 8'h3F;
        qx[0] = 10; qy[0] = 4;  qx[1] = 15; qy[1] = 4;
        qx[2] = 10; qy[2] = 6;  qx[3] = 15; qy[3] = 6;
        qx[4] = 40; qy[4] = 9;  qx[5] = 41; qy[5] = 9;
        do_read("R9 box corners", 8'h3F, 1'b0);
    endtask

    task automatic t_conflict();
        clear_req();
        qv = 8'h0F;
        qx[0] = 0;  qy[0] = 0;
        qx[1] = 16; qy[1] = 0;
        qx[2] = 3;  qy[2] = 1;
        qx[3] = 2;  qy[3] = 2;
        do_read("R7 winner and uncontested", 8'h0D, 1'b1);
    endtask

    task automatic t_mask();
        clear_req();
        qv = 8'h02;
        qx[0] = 0;  qy[0] = 0;
        qx[1] = 16; qy[1] = 0;
        do_read("R8 masked collider", 8'h02, 1'b0);
    endtask

    task automatic t_wrap();
        load_row(ROWS + 2);
        clear_req();
        qv = 8'h03;
        qx[0] = 9; qy[0] = ROWS + 2;
        qx[1] = 9; qy[1] = 3;
        do_read("R2 slot reuse", 8'h03, 1'b0);
    endtask

    task automatic t_concurrent();
        for (int b = 0; b < WPR; b++) begin
            clear_req();
            qv[0] = 1'b1; qx[0] = NBANK * b + 1; qy[0] = 5;
            @(negedge clk);
            load_beat(ROWS + 3, b);
            drive_req();
            finish_read("R11 read during load", 8'h01, 1'b0);
        end
        clear_req();
        qv = 8'h03;
        qx[0] = 0;  qy[0] = ROWS + 3;
        qx[1] = 17; qy[1] = ROWS + 3;
        do_read("R11 loaded row", 8'h03, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        for (int y = 0; y < ROWS; y++)
            load_row(y);
        t_single();
        t_parallel();
        t_haar();
        t_conflict();
        t_mask();
        t_wrap();
        t_concurrent();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule